// File: doc/BRIEF.md
# Converter Result Holding Registers with Ready Lock

This block keeps the most recent conversion word from each of two converters, a primary one and an auxiliary one. Each word sits in its own data register and has a ready flag. A ready flag goes high when a word is captured. While the flag is high, the block refuses any further word from that converter. This means software always reads a word that matches the flag it saw. Reading a data register over the register bus lowers the flags. The primary data register is normally the one that does this. When the primary converter is switched off, the auxiliary data register does it instead. While the processor core sleeps, the lock is lifted and each register follows the newest word.

A mask register selects which ready flags may raise the single interrupt output. Software polls the read-only status register to see which flag caused the interrupt. To get a matched pair of words, software reads the auxiliary word first and then the primary word. Neither register changes until the primary read lowers the flags.

Top module: `adc_result_regs`

## Requirements
- R1: While rst_n is low, and right after it is released, the status, mask and both data registers read zero and irq is low.
- R2: The bus address picks a register. Address 0 is status (read-only): bit 0 is the primary ready flag, bit 1 is the auxiliary ready flag, and writes to it are ignored. Address 1 is the mask: bits [1:0] can be written, and all other bits read zero. Address 2 is the primary data register and address 3 the auxiliary data register; both are zero-extended to the bus width. Every other address reads zero.
- R3: A done strobe from an enabled converter whose ready flag is low loads its data register and sets its ready flag at the same clock edge.
- R4: While a converter's ready flag is high, the core is awake and no clearing read occurs in that cycle, a done strobe changes neither its data register nor its flag.
- R5: A bus read of the primary data register clears both ready flags at the next edge.
- R6: When the primary converter is disabled, a bus read of the auxiliary data register clears both ready flags. When it is enabled, such a read clears nothing.
- R7: If a clearing read and a done strobe fall in the same cycle, that converter's new word is loaded and its flag ends high. The other flag is cleared.
- R8: While core_pd is high, every done strobe from an enabled converter loads its data register even if its flag is already high, and the flag ends high.
- R9: irq is high exactly when some ready flag is high together with its mask bit.
- R10: A done strobe from a disabled converter changes neither its data register nor its flag.
- R11: After both flags are set, an auxiliary data read followed by a primary data read returns the two captured words, even if new strobes arrive between the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read has side effects only on the data registers) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr (combinational) |
| pri_en | input | 1 | Primary converter enabled |
| aux_en | input | 1 | Auxiliary converter enabled |
| core_pd | input | 1 | Core powered down; lifts the lock |
| pri_done | input | 1 | Primary conversion complete strobe |
| pri_data | input | DATA_W | Primary conversion word |
| aux_done | input | 1 | Auxiliary conversion complete strobe |
| aux_data | input | DATA_W | Auxiliary conversion word |
| irq | output | 1 | Interrupt, OR of masked ready flags |

## Verification
A ready flag stuck high freezes its data register. A read of that register then returns an old word, and the interrupt stays asserted. A flag stuck low lets the next strobe overwrite a word that has not been read yet. Either fault shows on bus_rdata or irq one edge after the strobe or read that exposes it. A clear decoded on the wrong address or enable shows as a status readback that differs at the very next edge.

// File: rtl/adc_rr_pkg.sv
// Shared address map and sizes for the converter result registers.
// Assumes a narrow word-addressed register bus.
package adc_rr_pkg;
    localparam int ADDR_W = 3;
    localparam int NCH    = 2;
    localparam int CH_PRI = 0;
    localparam int CH_AUX = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 3'd0,
        REG_MASK = 3'd1,
        REG_PRI  = 3'd2,
        REG_AUX  = 3'd3
    } reg_sel_e;
endpackage

// File: rtl/adc_rr_chan.sv
// One converter holding register plus its ready flag.
// Assumes done_i is a single-cycle strobe qualified by din_i in the same cycle.
module adc_rr_chan #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic              en_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              clr_i,
    input  logic              pwrdn_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              rdy_o
);
    logic load;

    // A word may enter when the flag is free, being freed now, or the lock is lifted.
    assign load = en_i & done_i & (~rdy_o | clr_i | pwrdn_i);

    // Capture the word and keep the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_o <= '0;
            rdy_o  <= 1'b0;
        end else begin
            if (load) begin
                dout_o <= din_i;
                rdy_o  <= 1'b1;
            end else if (clr_i) begin
                rdy_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_rr_clear.sv
// Decides whether the current bus access clears all ready flags.
// Assumes bus_rd is high for exactly one cycle per read.
module adc_rr_clear
    import adc_rr_pkg::*;
(
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pri_en_i,
    output logic              clr_o
);
    // Primary read clears; auxiliary read clears only when primary is off.
    always_comb begin
        clr_o = 1'b0;
        if (rd_i) begin
            if (addr_i == REG_PRI)
                clr_o = 1'b1;
            else if (addr_i == REG_AUX && !pri_en_i)
                clr_o = 1'b1;
        end
    end
endmodule

// File: rtl/adc_rr_irq.sv
// Interrupt mask register and masked OR of ready flags.
// Assumes wr_i is already qualified by the mask address.
module adc_rr_irq #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [NCH-1:0] rdy_i,
    output logic [NCH-1:0] mask_o,
    output logic           irq_o
);
    // Hold the per-source enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_i)
            mask_o <= wdata_i;
    end

    // Any unmasked ready flag raises the interrupt.
    assign irq_o = |(rdy_i & mask_o);
endmodule

// File: rtl/adc_result_regs.sv
// Top: two converter holding registers with read-clear ready lock,
// a read-only status view, a mask register and one interrupt.
// Assumes DATA_W <= BUS_W and single-cycle bus strobes.
module adc_result_regs
    import adc_rr_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              pri_en,
    input  logic              aux_en,
    input  logic              core_pd,
    input  logic              pri_done,
    input  logic [DATA_W-1:0] pri_data,
    input  logic              aux_done,
    input  logic [DATA_W-1:0] aux_data,
    output logic              irq
);
    logic [NCH-1:0]             done_v;
    logic [NCH-1:0]             en_v;
    logic [NCH-1:0]             rdy_v;
    logic [NCH-1:0]             mask_v;
    logic [NCH-1:0][DATA_W-1:0] din_v;
    logic [NCH-1:0][DATA_W-1:0] dout_v;
    logic                       clr_all;
    logic                       unused_wdata;

    assign done_v[CH_PRI] = pri_done;
    assign done_v[CH_AUX] = aux_done;
    assign en_v[CH_PRI]   = pri_en;
    assign en_v[CH_AUX]   = aux_en;
    assign din_v[CH_PRI]  = pri_data;
    assign din_v[CH_AUX]  = aux_data;
    assign unused_wdata   = ^bus_wdata[BUS_W-1:NCH];

    adc_rr_clear u_clr (
        .rd_i     (bus_rd),
        .addr_i   (bus_addr),
        .pri_en_i (pri_en),
        .clr_o    (clr_all)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        adc_rr_chan #(.DATA_W(DATA_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .done_i  (done_v[g]),
            .en_i    (en_v[g]),
            .din_i   (din_v[g]),
            .clr_i   (clr_all),
            .pwrdn_i (core_pd),
            .dout_o  (dout_v[g]),
            .rdy_o   (rdy_v[g])
        );
    end

    adc_rr_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && (bus_addr == REG_MASK)),
        .wdata_i (bus_wdata[NCH-1:0]),
        .rdy_i   (rdy_v),
        .mask_o  (mask_v),
        .irq_o   (irq)
    );

    // Read multiplexer; unselected and unused bits return zero.
    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            REG_STAT: bus_rdata[NCH-1:0]    = rdy_v;
            REG_MASK: bus_rdata[NCH-1:0]    = mask_v;
            REG_PRI:  bus_rdata[DATA_W-1:0] = dout_v[CH_PRI];
            REG_AUX:  bus_rdata[DATA_W-1:0] = dout_v[CH_AUX];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_rr_chk.sv
// Checker for adc_result_regs, attached with bind below.
// Observes top-level ports and the per-channel register outputs.
module adc_rr_chk
    import adc_rr_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_rd,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       pri_en,
    input logic                       core_pd,
    input logic [NCH-1:0]             done_v,
    input logic [NCH-1:0]             en_v,
    input logic [NCH-1:0][DATA_W-1:0] din_v,
    input logic [NCH-1:0][DATA_W-1:0] dout_v,
    input logic [NCH-1:0]             rdy_v,
    input logic                       irq
);
    logic rd_pri, rd_aux, any_load_req;

    assign rd_pri       = bus_rd && (bus_addr == REG_PRI);
    assign rd_aux       = bus_rd && (bus_addr == REG_AUX);
    assign any_load_req = |(done_v & en_v);

    a_r5_pri_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pri && !any_load_req |=> rdy_v == '0);

    a_r6_aux_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rd_aux && pri_en |=> (rdy_v & $past(rdy_v)) == $past(rdy_v));

    a_r6_aux_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_aux && !pri_en && !any_load_req |=> rdy_v == '0);

    a_r9_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rdy_v != '0);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        a_r3_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
            en_v[g] && done_v[g] && !rdy_v[g] |=> rdy_v[g] && dout_v[g] == $past(din_v[g]));

        a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
            rdy_v[g] && !core_pd && !rd_pri && !(rd_aux && !pri_en)
            |=> rdy_v[g] && $stable(dout_v[g]));

        a_r8_pwrdn_follows: assert property (@(posedge clk) disable iff (!rst_n)
            core_pd && en_v[g] && done_v[g] |=> rdy_v[g] && dout_v[g] == $past(din_v[g]));

        a_r10_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            !en_v[g] |=> $stable(dout_v[g]));
    end
endmodule

bind adc_result_regs adc_rr_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .pri_en   (pri_en),
    .core_pd  (core_pd),
    .done_v   (done_v),
    .en_v     (en_v),
    .din_v    (din_v),
    .dout_v   (dout_v),
    .rdy_v    (rdy_v),
    .irq      (irq)
);

// File: tb/adc_result_regs_tb_top.sv
module adc_result_regs_tb_top;
    localparam int DATA_W = 24;
    localparam int BUS_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic             pri_en = 1'b1, aux_en = 1'b1, core_pd = 1'b0;
    logic             pri_done = 1'b0, aux_done = 1'b0;
    logic [DATA_W-1:0] pri_data = '0, aux_data = '0;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_result_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pri_en(pri_en), .aux_en(aux_en), .core_pd(core_pd),
        .pri_done(pri_done), .pri_data(pri_data),
        .aux_done(aux_done), .aux_data(aux_data), .irq(irq)
    );

    typedef struct packed {
        logic       pe, ae, pd, pdn;
        logic [7:0] pdat;
        logic       adn;
        logic [7:0] adat;
        logic       rd;
        logic [2:0] addr;
        logic [1:0] erdy;
        logic [7:0] epri, eaux;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1,1,0,1,8'h11,0,8'h00,0,3'd0,2'b01,8'h11,8'h00,4'd3},  // R3 primary load
        '{1,1,0,0,8'h00,1,8'h22,0,3'd0,2'b11,8'h11,8'h22,4'd3},  // R3 aux load
        '{1,1,0,1,8'h33,1,8'h44,0,3'd0,2'b11,8'h11,8'h22,4'd4},  // R4 both locked
        '{1,1,0,0,8'h00,0,8'h00,1,3'd3,2'b11,8'h11,8'h22,4'd6},  // R6 aux read, no clear
        '{1,1,0,0,8'h00,0,8'h00,1,3'd2,2'b00,8'h11,8'h22,4'd5},  // R5 primary read clears
        '{1,1,0,1,8'h55,0,8'h00,0,3'd0,2'b01,8'h55,8'h22,4'd3},  // R3
        '{1,1,0,1,8'h66,0,8'h00,1,3'd2,2'b01,8'h66,8'h22,4'd7},  // R7 clear + same load
        '{1,1,0,0,8'h00,1,8'h77,1,3'd2,2'b10,8'h66,8'h77,4'd7},  // R7 clear + other load
        '{0,1,0,0,8'h00,0,8'h00,1,3'd3,2'b00,8'h66,8'h77,4'd6},  // R6 aux read clears
        '{0,1,0,1,8'h88,0,8'h00,0,3'd0,2'b00,8'h66,8'h77,4'd10}, // R10 disabled strobe
        '{1,1,0,1,8'h99,0,8'h00,0,3'd0,2'b01,8'h99,8'h77,4'd3},  // R3
        '{1,1,1,1,8'hAA,0,8'h00,0,3'd0,2'b01,8'hAA,8'h77,4'd8},  // R8 lock lifted
        '{1,1,1,1,8'hBB,1,8'hCC,0,3'd0,2'b11,8'hBB,8'hCC,4'd8},  // R8
        '{1,1,0,1,8'hDD,0,8'h00,0,3'd0,2'b11,8'hBB,8'hCC,4'd4},  // R4 lock back
        '{1,1,0,0,8'h00,0,8'h00,1,3'd2,2'b00,8'hBB,8'hCC,4'd5}   // R5
    };

    task automatic check(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Look at a register without a read strobe (no side effect).
    task automatic peek(input logic [2:0] a, output logic [BUS_W-1:0] v);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle();
        bus_rd = 0; bus_wr = 0; pri_done = 0; aux_done = 0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); idle();
    endtask

    task automatic wr(input logic [2:0] a, input logic [BUS_W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; tick();
    endtask

    task automatic strobe(input logic p, input logic [7:0] pd, input logic x, input logic [7:0] xd);
        pri_done = p; pri_data = {16'h0, pd}; aux_done = x; aux_data = {16'h0, xd}; tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [BUS_W-1:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        peek(3'd0, v); check("R1 status in reset", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        peek(3'd0, v); check("R1 status", v, 0);
        peek(3'd1, v); check("R1 mask", v, 0);
        peek(3'd2, v); check("R1 primary data", v, 0);
        peek(3'd3, v); check("R1 aux data", v, 0);
        check("R1 irq", {31'h0, irq}, 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            pri_en = VEC[i].pe; aux_en = VEC[i].ae; core_pd = VEC[i].pd;
            pri_done = VEC[i].pdn; pri_data = {16'h0, VEC[i].pdat};
            aux_done = VEC[i].adn; aux_data = {16'h0, VEC[i].adat};
            bus_rd = VEC[i].rd; bus_addr = VEC[i].addr;
            tick();
            peek(3'd0, v); check({tag, " status"}, v, {30'h0, VEC[i].erdy});
            peek(3'd2, v); check({tag, " primary"}, v, {24'h0, VEC[i].epri});
            peek(3'd3, v); check({tag, " aux"}, v, {24'h0, VEC[i].eaux});
            check({tag, " irq masked off (R9)"}, {31'h0, irq}, 0);
        end
        pri_en = 1; aux_en = 1; core_pd = 0;

        // R9 masking
        wr(3'd1, 32'h1);
        peek(3'd1, v); check("R2 mask readback", v, 1);
        check("R9 irq no ready", {31'h0, irq}, 0);
        strobe(1, 8'h12, 0, 8'h00);
        check("R9 irq primary unmasked", {31'h0, irq}, 1);
        wr(3'd1, 32'h2);
        check("R9 irq primary masked", {31'h0, irq}, 0);
        strobe(0, 8'h00, 1, 8'h34);
        check("R9 irq aux unmasked", {31'h0, irq}, 1);
        // R2 register map corners
        wr(3'd1, 32'hFF);
        peek(3'd1, v); check("R2 mask upper bits zero", v, 3);
        wr(3'd0, 32'h0);
        peek(3'd0, v); check("R2 status write ignored", v, 3);
        peek(3'd5, v); check("R2 unused address", v, 0);

        // R11 matched pair: aux read, new strobes, then primary read
        bus_rd = 1; bus_addr = 3'd3;
        pri_done = 1; pri_data = 24'h56; aux_done = 1; aux_data = 24'h78;
        #1 check("R11 aux word", bus_rdata, 32'h34);
        tick();
        bus_rd = 1; bus_addr = 3'd2;
        #1 check("R11 primary word", bus_rdata, 32'h12);
        tick();
        peek(3'd0, v); check("R11 flags cleared", v, 0);
        strobe(1, 8'h56, 0, 8'h00);
        peek(3'd2, v); check("R11 next word loads", v, 32'h56);

        // R1 reset mid-run
        rst_n = 0; tick(); rst_n = 1; @(negedge clk);
        peek(3'd0, v); check("R1 status after reset", v, 0);
        peek(3'd2, v); check("R1 primary after reset", v, 0);
        peek(3'd1, v); check("R1 mask after reset", v, 0);
        summary();
    end
endmodule